// File: doc/BRIEF.md
# Microcoded Fetch-Execute Sequencer

This block is the control unit and register datapath of a small 8-bit accumulator machine. It connects to a single byte-wide memory port and runs every instruction as a fixed series of one-cycle steps. It fetches the opcode at the program counter and decodes it. It then reads any operand bytes one per cycle, moving the program counter forward after each byte. A final execute cycle reads or writes data memory, or updates the accumulator through a small arithmetic unit.

The opcode set is small. It covers accumulator loads with immediate, zero-page (direct) and full 16-bit (extended) addresses, and an extended store. It also has an immediate add, four register-only operations (negate, clear, arithmetic shift right, test) and an unconditional short branch. Any other opcode stops the machine: a `halted` output rises and all state stays frozen until reset. The accumulator, the program counter and the four condition flags are brought out as ports so the surrounding chip can observe them.

Top module: `acc_seq_top`

## Requirements
- R1: While reset is low, `pc` = 0x0800, `acc` = 0x00, `ccr` = 4'b0100, `halted` = 0 and `mem_we` = 0. `ccr` is ordered {N,Z,V,C}, bit 3 down to bit 0. Reset is released through a two-stage synchronizer, so the first opcode is fetched on the third rising edge after `rst_n` goes high.
- R2: Each memory access takes one cycle, and the address bus shows `pc` for every opcode and operand read. `pc` rises by one after each of those bytes. Execution takes 3 cycles for inherent and branch opcodes, 4 for immediate and direct, and 5 for extended.
- R3: Opcode 0xB6 (extended load) reads the address high byte, then the low byte. It then reads memory at that address into `acc`. N and Z follow the byte, V clears and C is kept.
- R4: Opcode 0x7A (extended store) forms its address the same way. It then writes `acc` there in a single write cycle and leaves `acc` and `pc` unchanged in that cycle. N and Z follow `acc`, V clears and C is kept.
- R5: Opcode 0x86 loads the next byte into `acc`, with the same flag rules as R3. Opcode 0x8B adds the next byte to `acc`. For the add, C is the carry out and V is signed overflow (both operands share a sign that the sum lacks). N and Z follow the sum.
- R6: Opcode 0x96 (direct load) takes one operand byte as the low address bits, with the high byte zero, and loads from there with the same flag rules as R3.
- R7: Opcode 0x40 replaces `acc` with its two's complement. C is set when the result is nonzero, V is set when the result is 0x80, and N and Z follow the result.
- R8: Opcode 0x87 clears `acc`. N, V and C clear and Z sets.
- R9: Opcode 0x47 shifts `acc` right one place and keeps bit 7. C gets the old bit 0, V = N xor C, and N and Z follow the result.
- R10: Opcode 0x97 leaves `acc` unchanged, sets N and Z from it, and clears V and C.
- R11: Opcode 0x20 loads `pc` with the branch's own address plus 2 plus the sign-extended offset byte. It leaves `acc` and the flags unchanged.
- R12: Any other opcode raises `halted` on the edge that ends its decode cycle, with `pc` one past that opcode. After that, `pc`, `acc` and `ccr` hold and no write happens until reset.
- R13: The opcode stream 0xB6 0x09 0x13 0x40 0x7A 0x09 0x14 at 0x0800, with 0x6C at 0x0913, writes 0x94 to 0x0914 and leaves `pc` = 0x0807 after 13 instruction cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized internally on release |
| mem_addr | output | 16 | Memory address: `pc` for opcode and operand reads, the effective address in the execute cycle |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_addr` |
| mem_we | output | 1 | Write strobe; the write takes effect on the next rising edge |
| mem_wdata | output | 8 | Write data |
| pc | output | 16 | Program counter |
| acc | output | 8 | Accumulator |
| ccr | output | 4 | Condition flags {N,Z,V,C} |
| halted | output | 1 | High after an undefined opcode has been decoded |

## Verification
Every result has a cycle it is due in. The bench counts rising edges from the falling edge at which it releases reset. The first opcode cycle ends on edge 3. After that, each instruction adds 3, 4 or 5 edges according to its addressing mode. For example, the reference program's store strobe is visible just after edge 14, and its memory result and final `pc` just after edge 15. Outputs are sampled on the falling edge after the counted rising edge. Several scenarios also sample the address bus inside an execute cycle, the halt flag on the edge that ends decode, and `pc` after each branch. This pins down the timing as well as the values.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2 * DATA_W;

  localparam logic [DATA_W-1:0] OPC_LDA_EXT = 8'hB6;
  localparam logic [DATA_W-1:0] OPC_STA_EXT = 8'h7A;
  localparam logic [DATA_W-1:0] OPC_LDA_IMM = 8'h86;
  localparam logic [DATA_W-1:0] OPC_ADD_IMM = 8'h8B;
  localparam logic [DATA_W-1:0] OPC_LDA_DIR = 8'h96;
  localparam logic [DATA_W-1:0] OPC_NEG     = 8'h40;
  localparam logic [DATA_W-1:0] OPC_CLR     = 8'h87;
  localparam logic [DATA_W-1:0] OPC_ASR     = 8'h47;
  localparam logic [DATA_W-1:0] OPC_TST     = 8'h97;
  localparam logic [DATA_W-1:0] OPC_BRA     = 8'h20;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_ADDR_HI, ST_ADDR_LO,
    ST_IMM, ST_REL, ST_EXEC, ST_HALT
  } seq_state_e;

  typedef enum logic [2:0] {
    AM_INH, AM_IMM, AM_DIR, AM_EXT, AM_REL, AM_BAD
  } addr_mode_e;

  typedef enum logic [2:0] {
    FN_NONE, FN_LOAD, FN_STORE, FN_ADD, FN_NEG, FN_CLR, FN_ASR, FN_TST
  } alu_fn_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};

endpackage

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
  import acc_seq_pkg::*;
(
  input  logic [DATA_W-1:0] opcode,
  output addr_mode_e        mode,
  output alu_fn_e           fn
);

  always_comb begin
    mode = AM_BAD;
    fn   = FN_NONE;
    case (opcode)
      OPC_LDA_EXT: begin mode = AM_EXT; fn = FN_LOAD;  end
      OPC_STA_EXT: begin mode = AM_EXT; fn = FN_STORE; end
      OPC_LDA_IMM: begin mode = AM_IMM; fn = FN_LOAD;  end
      OPC_ADD_IMM: begin mode = AM_IMM; fn = FN_ADD;   end
      OPC_LDA_DIR: begin mode = AM_DIR; fn = FN_LOAD;  end
      OPC_NEG:     begin mode = AM_INH; fn = FN_NEG;   end
      OPC_CLR:     begin mode = AM_INH; fn = FN_CLR;   end
      OPC_ASR:     begin mode = AM_INH; fn = FN_ASR;   end
      OPC_TST:     begin mode = AM_INH; fn = FN_TST;   end
      OPC_BRA:     begin mode = AM_REL; fn = FN_NONE;  end
      default:     begin mode = AM_BAD; fn = FN_NONE;  end
    endcase
  end

endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
  import acc_seq_pkg::*;
(
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  flags_t            flags_in,
  output logic [DATA_W-1:0] result,
  output flags_t            flags_out
);

  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W:0]   sum_ext;
  logic [DATA_W-1:0] neg_val;

  always_comb begin
    sum_ext = {1'b0, a} + {1'b0, b};
    neg_val = (~a) + {{(DATA_W-1){1'b0}}, 1'b1};
  end

  always_comb begin
    result    = a;
    flags_out = flags_in;
    case (fn)
      FN_LOAD: begin
        result      = b;
        flags_out.v = 1'b0;
      end
      FN_STORE: begin
        result      = a;
        flags_out.v = 1'b0;
      end
      FN_ADD: begin
        result      = sum_ext[DATA_W-1:0];
        flags_out.c = sum_ext[DATA_W];
        flags_out.v = (a[MSB] == b[MSB]) && (sum_ext[MSB] != a[MSB]);
      end
      FN_NEG: begin
        result      = neg_val;
        flags_out.c = (neg_val != '0);
        flags_out.v = (neg_val == {1'b1, {(DATA_W-1){1'b0}}});
      end
      FN_CLR: begin
        result      = '0;
        flags_out.c = 1'b0;
        flags_out.v = 1'b0;
      end
      FN_ASR: begin
        result      = {a[MSB], a[MSB:1]};
        flags_out.c = a[0];
        flags_out.v = a[MSB] ^ a[0];
      end
      FN_TST: begin
        result      = a;
        flags_out.c = 1'b0;
        flags_out.v = 1'b0;
      end
      default: begin
        result    = a;
        flags_out = flags_in;
      end
    endcase
    if (fn != FN_NONE) begin
      flags_out.n = result[MSB];
      flags_out.z = (result == '0);
    end
  end

endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  addr_mode_e mode,
  output seq_state_e state
);

  seq_state_e state_d;
  seq_state_e state_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        case (mode)
          AM_INH:  state_d = ST_EXEC;
          AM_IMM:  state_d = ST_IMM;
          AM_DIR:  state_d = ST_ADDR_LO;
          AM_EXT:  state_d = ST_ADDR_HI;
          AM_REL:  state_d = ST_REL;
          default: state_d = ST_HALT;
        endcase
      end
      ST_ADDR_HI: state_d = ST_ADDR_LO;
      ST_ADDR_LO: state_d = ST_EXEC;
      ST_IMM:     state_d = ST_EXEC;
      ST_REL:     state_d = ST_FETCH;
      ST_EXEC:    state_d = ST_FETCH;
      ST_HALT:    state_d = ST_HALT;
      default:    state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
  import acc_seq_pkg::*;
#(
  parameter logic [15:0] RESET_PC    = 16'h0800,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  output logic [15:0] pc,
  output logic [7:0]  acc,
  output logic [3:0]  ccr,
  output logic        halted
);

  localparam int unsigned HI_LSB = ADDR_W - DATA_W;

  // reset synchronizer: asserts at once, releases after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_sync_n;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  // architectural and working registers
  logic [ADDR_W-1:0] pc_q,   pc_d;
  logic [DATA_W-1:0] ir_q,   ir_d;
  logic [ADDR_W-1:0] ea_q,   ea_d;
  logic [DATA_W-1:0] imm_q,  imm_d;
  logic [DATA_W-1:0] acc_q,  acc_d;
  flags_t            flg_q,  flg_d;

  logic pc_en, ir_en, ea_en, imm_en, acc_en;

  seq_state_e        state;
  addr_mode_e        mode;
  alu_fn_e           fn;
  logic [DATA_W-1:0] alu_b;
  logic [DATA_W-1:0] alu_res;
  flags_t            alu_flg;
  logic [ADDR_W-1:0] rel_off;

  acc_seq_decode u_decode (
    .opcode (ir_q),
    .mode   (mode),
    .fn     (fn)
  );

  acc_seq_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .mode  (mode),
    .state (state)
  );

  assign alu_b = (mode == AM_IMM) ? imm_q : mem_rdata;

  acc_seq_alu u_alu (
    .fn        (fn),
    .a         (acc_q),
    .b         (alu_b),
    .flags_in  (flg_q),
    .result    (alu_res),
    .flags_out (alu_flg)
  );

  assign rel_off = {{HI_LSB{mem_rdata[DATA_W-1]}}, mem_rdata};

  // next-state values and clock enables
  always_comb begin
    pc_en  = 1'b0;
    ir_en  = 1'b0;
    ea_en  = 1'b0;
    imm_en = 1'b0;
    acc_en = 1'b0;
    pc_d   = pc_q + {{(ADDR_W-1){1'b0}}, 1'b1};
    ir_d   = mem_rdata;
    ea_d   = ea_q;
    imm_d  = mem_rdata;
    acc_d  = alu_res;
    flg_d  = alu_flg;
    case (state)
      ST_FETCH: begin
        pc_en = 1'b1;
        ir_en = 1'b1;
      end
      ST_DECODE: begin
        if (mode == AM_DIR) begin
          ea_en = 1'b1;
          ea_d  = '0;
        end
      end
      ST_ADDR_HI: begin
        pc_en = 1'b1;
        ea_en = 1'b1;
        ea_d  = {mem_rdata, ea_q[HI_LSB-1:0]};
      end
      ST_ADDR_LO: begin
        pc_en = 1'b1;
        ea_en = 1'b1;
        ea_d  = {ea_q[ADDR_W-1:HI_LSB], mem_rdata};
      end
      ST_IMM: begin
        pc_en  = 1'b1;
        imm_en = 1'b1;
      end
      ST_REL: begin
        pc_en = 1'b1;
        pc_d  = pc_q + {{(ADDR_W-1){1'b0}}, 1'b1} + rel_off;
      end
      ST_EXEC: begin
        acc_en = 1'b1;
      end
      default: begin
        pc_en = 1'b0;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q  <= RESET_PC;
      ir_q  <= '0;
      ea_q  <= '0;
      imm_q <= '0;
      acc_q <= '0;
      flg_q <= FLAGS_RESET;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (ir_en)  ir_q  <= ir_d;
      if (ea_en)  ea_q  <= ea_d;
      if (imm_en) imm_q <= imm_d;
      if (acc_en) begin
        acc_q <= acc_d;
        flg_q <= flg_d;
      end
    end
  end

  assign mem_addr  = (state == ST_EXEC) ? ea_q : pc_q;
  assign mem_we    = (state == ST_EXEC) && (fn == FN_STORE);
  assign mem_wdata = acc_q;
  assign pc        = pc_q;
  assign acc       = acc_q;
  assign ccr       = flg_q;
  assign halted    = (state == ST_HALT);

endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        halted,
  input logic        mem_we,
  input logic [15:0] pc,
  input logic [7:0]  acc,
  input logic [3:0]  ccr
);

  // R12: once stopped, the machine stays stopped
  a_r12_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R12: no architectural state moves while stopped
  a_r12_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(pc) && $stable(acc) && $stable(ccr)));

  // R12: a stopped machine never writes
  a_r12_halt_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  // R4: a store writes in exactly one cycle
  a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R4: the write cycle changes neither the accumulator nor the program counter
  a_r4_write_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ($stable(acc) && $stable(pc)));

  // R1, R3: N and Z always describe the accumulator (every opcode that writes it also sets them)
  a_r1_nz_track: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr[3] == acc[7]) && (ccr[2] == (acc == 8'h00)));

endmodule

bind acc_seq_top acc_seq_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .halted (halted),
  .mem_we (mem_we),
  .pc     (pc),
  .acc    (acc),
  .ccr    (ccr)
);

// File: tb/acc_seq_top_tb.sv
`timescale 1ns/1ps
module acc_seq_top_tb;

  logic        clk;
  logic        rst_n;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [15:0] pc;
  logic [7:0]  acc;
  logic [3:0]  ccr;
  logic        halted;

  logic [7:0] mem [0:4095];
  int         wr_count;
  int         n_tests;
  int         n_fail;

  acc_seq_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .pc        (pc),
    .acc       (acc),
    .ccr       (ccr),
    .halted    (halted)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr[11:0]];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    check(act == exp, req, what, act, exp);
  endtask

  // hold reset, clear memory
  task automatic begin_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    wr_count = 0;
  endtask

  task automatic put(input int addr, input logic [7:0] val);
    mem[addr[11:0]] = val;
  endtask

  // release reset on a falling edge and stop at the falling edge after rising edge n
  task automatic release_run(input int n);
    rst_n = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_more(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    begin_reset();
    chk_eq("R1", "pc in reset", pc, 16'h0800);
    chk_eq("R1", "acc in reset", acc, 8'h00);
    chk_eq("R1", "ccr in reset", ccr, 4'b0100);
    chk_eq("R1", "halted in reset", halted, 0);
    chk_eq("R1", "mem_we in reset", mem_we, 0);
    put(16'h0800, 8'h87);
    release_run(2);
    chk_eq("R1", "pc before first fetch", pc, 16'h0800);
    run_more(1);
    chk_eq("R1", "pc after first fetch edge", pc, 16'h0801);
  endtask

  task automatic t_reference();
    begin_reset();
    put(16'h0800, 8'hB6); put(16'h0801, 8'h09); put(16'h0802, 8'h13);
    put(16'h0803, 8'h40);
    put(16'h0804, 8'h7A); put(16'h0805, 8'h09); put(16'h0806, 8'h14);
    put(16'h0913, 8'h6C);
    release_run(6);
    chk_eq("R3", "load ext effective address", mem_addr, 16'h0913);
    run_more(1);
    chk_eq("R3", "acc after ext load", acc, 8'h6C);
    chk_eq("R2", "pc after 3-byte load", pc, 16'h0803);
    run_more(7);
    chk_eq("R4", "store strobe", mem_we, 1);
    chk_eq("R4", "store address", mem_addr, 16'h0914);
    chk_eq("R4", "store data", mem_wdata, 8'h94);
    run_more(1);
    chk_eq("R13", "result byte", mem[12'h914], 8'h94);
    chk_eq("R13", "final pc", pc, 16'h0807);
    chk_eq("R13", "source byte kept", mem[12'h913], 8'h6C);
    chk_eq("R7", "acc after negate", acc, 8'h94);
    chk_eq("R4", "flags after store", ccr, 4'b1001);
    chk_eq("R4", "write count", wr_count, 1);
  endtask

  task automatic t_store_flags();
    begin_reset();
    put(16'h0800, 8'h86); put(16'h0801, 8'h80);
    put(16'h0802, 8'h40);
    put(16'h0803, 8'h7A); put(16'h0804, 8'h09); put(16'h0805, 8'h00);
    release_run(13);
    chk_eq("R4", "store strobe", mem_we, 1);
    chk_eq("R4", "store address", mem_addr, 16'h0900);
    run_more(1);
    chk_eq("R4", "stored byte", mem[12'h900], 8'h80);
    chk_eq("R4", "store clears V keeps C", ccr, 4'b1001);
    chk_eq("R4", "single write", wr_count, 1);
  endtask

  task automatic t_immediate();
    begin_reset();
    put(16'h0800, 8'h86); put(16'h0801, 8'h7F);
    put(16'h0802, 8'h8B); put(16'h0803, 8'h01);
    put(16'h0804, 8'h8B); put(16'h0805, 8'h80);
    release_run(6);
    chk_eq("R5", "acc after imm load", acc, 8'h7F);
    chk_eq("R5", "flags after imm load", ccr, 4'b0000);
    run_more(4);
    chk_eq("R5", "acc after add overflow", acc, 8'h80);
    chk_eq("R5", "flags add 7F+01", ccr, 4'b1010);
    run_more(4);
    chk_eq("R5", "acc after add carry", acc, 8'h00);
    chk_eq("R5", "flags add 80+80", ccr, 4'b0111);
    chk_eq("R2", "pc after three 2-byte ops", pc, 16'h0806);
  endtask

  task automatic t_direct();
    begin_reset();
    put(16'h0800, 8'h86); put(16'h0801, 8'h01);
    put(16'h0802, 8'h47);
    put(16'h0803, 8'h96); put(16'h0804, 8'h20);
    put(16'h0020, 8'h85);
    release_run(9);
    chk_eq("R9", "acc after shift of 01", acc, 8'h00);
    chk_eq("R9", "flags after shift of 01", ccr, 4'b0111);
    run_more(3);
    chk_eq("R6", "direct effective address", mem_addr, 16'h0020);
    run_more(1);
    chk_eq("R6", "acc after direct load", acc, 8'h85);
    chk_eq("R6", "load keeps C clears V", ccr, 4'b1001);
    chk_eq("R6", "pc after direct", pc, 16'h0805);
  endtask

  task automatic t_inherent();
    begin_reset();
    put(16'h0800, 8'h86); put(16'h0801, 8'h81);
    put(16'h0802, 8'h47);
    put(16'h0803, 8'h97);
    put(16'h0804, 8'h87);
    put(16'h0805, 8'h40);
    put(16'h0806, 8'h86); put(16'h0807, 8'h80);
    put(16'h0808, 8'h40);
    release_run(9);
    chk_eq("R9", "acc after shift of 81", acc, 8'hC0);
    chk_eq("R9", "flags after shift of 81", ccr, 4'b1001);
    run_more(3);
    chk_eq("R10", "acc after test", acc, 8'hC0);
    chk_eq("R10", "flags after test", ccr, 4'b1000);
    run_more(3);
    chk_eq("R8", "acc after clear", acc, 8'h00);
    chk_eq("R8", "flags after clear", ccr, 4'b0100);
    run_more(3);
    chk_eq("R7", "acc after negate of 0", acc, 8'h00);
    chk_eq("R7", "flags negate of 0", ccr, 4'b0100);
    run_more(7);
    chk_eq("R7", "acc after negate of 80", acc, 8'h80);
    chk_eq("R7", "flags negate of 80", ccr, 4'b1011);
    chk_eq("R2", "pc after inherent run", pc, 16'h0809);
    chk_eq("R2", "no data writes", wr_count, 0);
  endtask

  task automatic t_branch();
    begin_reset();
    put(16'h0800, 8'h20); put(16'h0801, 8'h1E);
    put(16'h0820, 8'h20); put(16'h0821, 8'h0E);
    put(16'h0830, 8'h20); put(16'h0831, 8'hF0);
    put(16'h0822, 8'h86); put(16'h0823, 8'h55);
    release_run(5);
    chk_eq("R11", "pc after forward branch", pc, 16'h0820);
    chk_eq("R11", "flags kept by branch", ccr, 4'b0100);
    run_more(3);
    chk_eq("R11", "pc after 0E branch", pc, 16'h0830);
    run_more(3);
    chk_eq("R11", "pc after backward branch", pc, 16'h0822);
    run_more(4);
    chk_eq("R11", "acc at branch target", acc, 8'h55);
    chk_eq("R11", "pc after target load", pc, 16'h0824);
    run_more(2);
    chk_eq("R12", "halt on 00", halted, 1);
    chk_eq("R12", "pc after 00", pc, 16'h0825);
  endtask

  task automatic t_halt();
    begin_reset();
    release_run(3);
    chk_eq("R12", "not halted before decode", halted, 0);
    run_more(1);
    chk_eq("R12", "halted after decode", halted, 1);
    chk_eq("R12", "pc past bad opcode", pc, 16'h0801);
    run_more(20);
    chk_eq("R12", "still halted", halted, 1);
    chk_eq("R12", "pc frozen", pc, 16'h0801);
    chk_eq("R12", "no writes when halted", wr_count, 0);

    begin_reset();
    put(16'h0800, 8'h86); put(16'h0801, 8'h3C);
    put(16'h0802, 8'hFF);
    put(16'h0803, 8'h7A); put(16'h0804, 8'h09); put(16'h0805, 8'h00);
    release_run(7);
    chk_eq("R12", "running before FF decode", halted, 0);
    run_more(1);
    chk_eq("R12", "halt on FF", halted, 1);
    chk_eq("R12", "pc after FF", pc, 16'h0803);
    run_more(10);
    chk_eq("R12", "acc frozen", acc, 8'h3C);
    chk_eq("R12", "store after FF never runs", wr_count, 0);
  endtask

  initial begin
    #(200000 * 20);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests  = 0;
    n_fail   = 0;
    wr_count = 0;
    rst_n    = 1'b0;
    t_reset();
    t_reference();
    t_store_flags();
    t_immediate();
    t_direct();
    t_inherent();
    t_branch();
    t_halt();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule